// File: doc/BRIEF.md
# Floppy Disc Word DMA Engine

This block carries 16-bit words between system memory and the byte-wide data port of a floppy disc controller. Software programs a word address and a combined count/control word. The engine then runs on its own. In the disc-to-memory direction it collects two bytes from the controller and stores them as one word. In the memory-to-disc direction it fetches one word and hands it to the controller as two bytes. The controller paces every byte with its data-request line. The memory side waits for a grant on every word.

The count runs upward, and the transfer ends when the count overflows its 14-bit range. At that point the count returns to zero, the engine stops and a one-cycle done pulse is raised. When the engine is enabled, the count moves up by one before any data moves, so a programmed count C moves 0x3FFF − C words. The engine moves at most a fixed number of words per scheduling slot. Once that budget is spent it parks until the next slot tick.

The controller is a single state machine:
- ST_IDLE: stopped.
- ST_PGET_HI and ST_PGET_LO: take a byte from the peripheral.
- ST_MWRITE: store the word.
- ST_MREAD: fetch a word.
- ST_PPUT_HI and ST_PPUT_LO: give a byte to the peripheral.
- ST_PARK: slot budget spent.

The transitions are:
- A count write with the enable set goes to ST_PGET_HI or ST_MREAD, depending on the direction.
- A count write with the enable clear goes to ST_IDLE.
- Each byte state advances on data request.
- Each memory state advances on grant.
- At the end of a word the engine goes to ST_IDLE if that word completed the count, to ST_PARK if the budget is spent, and otherwise starts the next word.
- ST_PARK leaves on a slot tick.

Top module: `fdma_engine`

## Requirements
- R1: A count-register write (reg_wr=1, reg_sel=0) loads the count from reg_wdata[13:0], the direction from reg_wdata[14] (1 = memory to peripheral, 0 = peripheral to memory) and the enable from reg_wdata[15]. With the enable clear, no transfer takes place.
- R2: Each moved word adds one to the count. The word that carries the count from 0x3FFF to zero ends the transfer. The count then reads zero, done is high for exactly the next cycle, and no further memory or peripheral strobes occur.
- R3: A write with the enable set stores the programmed count plus one, so reading back in the next cycle gives C+1. A value of 0x3FFF with the enable set completes at once: done pulses and no data moves.
- R4: reg_rdata returns the count in bits 13:0, with bit 14 reading 0 and bit 15 always reading 1 (error flag inactive).
- R5: mem_addr is the word address shifted left by one bit. The word address increases by one after each moved word.
- R6: An address-register write (reg_wr=1, reg_sel=1) with reg_addr[14]=0 replaces word-address bits 7:0 with reg_addr[7:0]. With reg_addr[14]=1 it replaces bits 21:8 with reg_addr[13:0]. The other bits are kept in both cases.
- R7: While per_drq is low, per_rd and per_wr stay low, and the engine waits without losing its place. It resumes when per_drq returns.
- R8: Peripheral to memory: the first byte taken becomes bits 15:8 of the stored word and the second byte becomes bits 7:0.
- R9: Memory to peripheral: bits 15:8 of the fetched word are sent first, then bits 7:0.
- R10: At most SLOT_WORDS words are moved after an enabling write or a slot_tick. The engine then waits for slot_tick and continues.
- R11: A memory request stays asserted with the same direction until mem_gnt is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = count/control, 1 = word address |
| reg_addr | input | 15 | Bus address lines; selects the half and carries the data for address writes |
| reg_wdata | input | 16 | Count/control write data |
| reg_rdata | output | 16 | Count readback |
| slot_tick | input | 1 | Start of a new scheduling slot |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write to memory |
| mem_addr | output | 23 | Memory byte address |
| mem_wdata | output | 16 | Word to store |
| mem_rdata | input | 16 | Fetched word, valid with grant |
| mem_gnt | input | 1 | Memory grant |
| per_drq | input | 1 | Peripheral data request |
| per_rd | output | 1 | Take per_rdata this cycle |
| per_rdata | input | 8 | Byte from peripheral |
| per_wr | output | 1 | per_wdata is valid this cycle |
| per_wdata | output | 8 | Byte to peripheral |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong state shows up at the ports within one word time (three cycles when request and grant are steady). Symptoms include:
- a strobe that appears without a data request;
- a swapped byte pair in memory or in the outgoing byte stream;
- a memory address that does not step by two.

A miscounted length or a broken skip-on-enable shows up in the count readback in the cycle after the enabling write. It also shows as a word too many or too few before done. A broken slot budget appears as a count that keeps moving with no slot tick.

// File: rtl/fdma_pkg.sv
package fdma_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PGET_HI,
        ST_PGET_LO,
        ST_MWRITE,
        ST_MREAD,
        ST_PPUT_HI,
        ST_PPUT_LO,
        ST_PARK
    } fdma_state_e;
endpackage

// File: rtl/fdma_regs.sv
module fdma_regs #(
    parameter  int CW = 14,
    parameter  int AW = 22,
    localparam int RW = CW + 2,
    localparam int HW = AW - 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cnt_wr,
    input  logic          adr_wr,
    input  logic [RW-1:0] wdata,
    input  logic [HW:0]   badr,
    input  logic          word_done,
    output logic [CW-1:0] count_q,
    output logic          dir_q,
    output logic [AW-1:0] waddr_q,
    output logic          kick,
    output logic          done_q
);
    logic en_bit, full_field, end_now;

    assign en_bit     = wdata[RW-1];
    assign full_field = &wdata[CW-1:0];
    assign kick       = cnt_wr & en_bit & ~full_field;
    assign end_now    = cnt_wr & en_bit & full_field;

    // count, direction and completion pulse (R1, R2, R3)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            dir_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= end_now | (~cnt_wr & word_done & (&count_q));
            if (cnt_wr) begin
                dir_q <= wdata[CW];
                if (!en_bit)
                    count_q <= wdata[CW-1:0];
                else
                    count_q <= wdata[CW-1:0] + 1'b1;  // all ones wraps to zero
            end else if (word_done) begin
                count_q <= count_q + 1'b1;
            end
        end
    end

    // word address, loaded by halves (R5, R6)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            waddr_q <= '0;
        end else if (adr_wr) begin
            if (badr[HW])
                waddr_q[AW-1:8] <= badr[HW-1:0];
            else
                waddr_q[7:0] <= badr[7:0];
        end else if (word_done) begin
            waddr_q <= waddr_q + 1'b1;
        end
    end
endmodule

// File: rtl/fdma_slot.sv
module fdma_slot #(
    parameter  int SLOT_WORDS = 16,
    localparam int SW = $clog2(SLOT_WORDS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slot_tick,
    input  logic kick,
    input  logic word_done,
    output logic budget_last
);
    logic [SW-1:0] used_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            used_q <= '0;
        else if (slot_tick || kick)
            used_q <= '0;
        else if (word_done)
            used_q <= used_q + 1'b1;
    end

    assign budget_last = (used_q == SW'(SLOT_WORDS - 1));
endmodule

// File: rtl/fdma_fsm.sv
module fdma_fsm
    import fdma_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cnt_wr,
    input  logic        kick,
    input  logic        kick_dir,
    input  logic        dir_q,
    input  logic        last_word,
    input  logic        budget_last,
    input  logic        slot_tick,
    input  logic        per_drq,
    input  logic [7:0]  per_rdata,
    input  logic        mem_gnt,
    input  logic [15:0] mem_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [15:0] mem_wdata,
    output logic        per_rd,
    output logic        per_wr,
    output logic [7:0]  per_wdata,
    output logic        word_done
);
    fdma_state_e st_q, st_d;
    logic [15:0] word_q;

    function automatic fdma_state_e after_word(input fdma_state_e cont, input logic last,
                                               input logic spent, input logic tick);
        if (last)
            return ST_IDLE;
        else if (spent && !tick)
            return ST_PARK;
        else
            return cont;
    endfunction

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:    st_d = ST_IDLE;
            ST_PGET_HI: if (per_drq) st_d = ST_PGET_LO;
            ST_PGET_LO: if (per_drq) st_d = ST_MWRITE;
            ST_MWRITE:  if (mem_gnt) st_d = after_word(ST_PGET_HI, last_word, budget_last, slot_tick);
            ST_MREAD:   if (mem_gnt) st_d = ST_PPUT_HI;
            ST_PPUT_HI: if (per_drq) st_d = ST_PPUT_LO;
            ST_PPUT_LO: if (per_drq) st_d = after_word(ST_MREAD, last_word, budget_last, slot_tick);
            ST_PARK:    if (slot_tick) st_d = dir_q ? ST_MREAD : ST_PGET_HI;
            default:    st_d = ST_IDLE;
        endcase
        if (cnt_wr)
            st_d = kick ? (kick_dir ? ST_MREAD : ST_PGET_HI) : ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= ST_IDLE;
        else
            st_q <= st_d;
    end

    // word assembly / holding register (R8, R9)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            word_q <= '0;
        else if (st_q == ST_PGET_HI && per_drq)
            word_q[15:8] <= per_rdata;
        else if (st_q == ST_PGET_LO && per_drq)
            word_q[7:0] <= per_rdata;
        else if (st_q == ST_MREAD && mem_gnt)
            word_q <= mem_rdata;
    end

    always_comb begin
        mem_req   = (st_q == ST_MWRITE) || (st_q == ST_MREAD);
        mem_we    = (st_q == ST_MWRITE);
        mem_wdata = word_q;
        per_rd    = per_drq && ((st_q == ST_PGET_HI) || (st_q == ST_PGET_LO));
        per_wr    = per_drq && ((st_q == ST_PPUT_HI) || (st_q == ST_PPUT_LO));
        per_wdata = (st_q == ST_PPUT_HI) ? word_q[15:8] : word_q[7:0];
        word_done = ((st_q == ST_MWRITE) && mem_gnt) || ((st_q == ST_PPUT_LO) && per_drq);
    end
endmodule

// File: rtl/fdma_engine.sv
module fdma_engine #(
    parameter  int CW         = 14,
    parameter  int AW         = 22,
    parameter  int SLOT_WORDS = 16,
    localparam int RW         = CW + 2,
    localparam int HW         = AW - 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_sel,
    input  logic [HW:0]   reg_addr,
    input  logic [RW-1:0] reg_wdata,
    output logic [RW-1:0] reg_rdata,
    input  logic          slot_tick,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW:0]   mem_addr,
    output logic [15:0]   mem_wdata,
    input  logic [15:0]   mem_rdata,
    input  logic          mem_gnt,
    input  logic          per_drq,
    output logic          per_rd,
    input  logic [7:0]    per_rdata,
    output logic          per_wr,
    output logic [7:0]    per_wdata,
    output logic          done
);
    logic          cnt_wr, adr_wr, kick, dir_q, word_done, budget_last;
    logic [CW-1:0] count_q;
    logic [AW-1:0] waddr_q;

    assign cnt_wr = reg_wr & ~reg_sel;
    assign adr_wr = reg_wr & reg_sel;

    fdma_regs #(.CW(CW), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr), .adr_wr(adr_wr),
        .wdata(reg_wdata), .badr(reg_addr), .word_done(word_done),
        .count_q(count_q), .dir_q(dir_q), .waddr_q(waddr_q),
        .kick(kick), .done_q(done)
    );

    fdma_slot #(.SLOT_WORDS(SLOT_WORDS)) u_slot (
        .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick), .kick(kick),
        .word_done(word_done), .budget_last(budget_last)
    );

    fdma_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr), .kick(kick),
        .kick_dir(reg_wdata[CW]), .dir_q(dir_q), .last_word(&count_q),
        .budget_last(budget_last), .slot_tick(slot_tick),
        .per_drq(per_drq), .per_rdata(per_rdata),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .per_rd(per_rd), .per_wr(per_wr), .per_wdata(per_wdata),
        .word_done(word_done)
    );

    assign reg_rdata = {1'b1, 1'b0, count_q};
    assign mem_addr  = {waddr_q, 1'b0};
endmodule

// File: rtl/fdma_engine_chk.sv
module fdma_engine_chk #(
    parameter int RW = 16,
    parameter int AW = 22
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic [RW-1:0] reg_rdata,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_gnt,
    input logic [AW:0]   mem_addr,
    input logic          per_drq,
    input logic          per_rd,
    input logic          per_wr,
    input logic          done
);
    AST_RDBK_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[RW-1] && !reg_rdata[RW-2]);  // R4

    AST_DONE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> reg_rdata == {1'b1, {(RW-1){1'b0}}});  // R2

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req && !per_rd && !per_wr);  // R2

    AST_NO_DRQ_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !per_drq |-> !per_rd && !per_wr);  // R7

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_gnt && !reg_wr) |=> mem_addr == $past(mem_addr) + (AW+1)'(2));  // R5

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt && !reg_wr) |=> mem_req && (mem_we == $past(mem_we)));  // R11
endmodule

bind fdma_engine fdma_engine_chk #(.RW(RW), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_gnt(mem_gnt), .mem_addr(mem_addr),
    .per_drq(per_drq), .per_rd(per_rd), .per_wr(per_wr), .done(done)
);

// File: tb/fdma_engine_bench.sv
`timescale 1ns/1ps
module fdma_engine_bench;
    localparam int SLOT = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_sel = 1'b0, slot_tick = 1'b0;
    logic [14:0] reg_addr = '0;
    logic [15:0] reg_wdata = '0, reg_rdata;
    logic        mem_req, mem_we, mem_gnt = 1'b0;
    logic [22:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata = '0;
    logic        per_drq = 1'b0, per_rd, per_wr, done;
    logic [7:0]  per_rdata = '0, per_wdata;

    fdma_engine #(.SLOT_WORDS(SLOT)) u_fdma_engine (.*);

    always #10 clk = ~clk;  // 50 MHz

    int checks = 0, errors = 0;
    int drq_mode = 1, gnt_mode = 1;  // 0 random, 1 on, 2 off
    logic [7:0]  src [0:1023];
    logic [7:0]  sink [0:1023];
    logic [15:0] mem [0:255];
    logic [22:0] wr_log [0:255];
    int src_ptr = 0, sink_ptr = 0, wr_n = 0, rd_n = 0, done_n = 0;

    // memory and peripheral models: drive at negedge, record strobes before the next edge
    always @(negedge clk) begin
        per_drq   = (drq_mode == 1) || (drq_mode == 0 && ($urandom % 3) != 0);
        mem_gnt   = mem_req && ((gnt_mode == 1) || (gnt_mode == 0 && ($urandom % 4) != 0));
        per_rdata = src[src_ptr & 1023];
        mem_rdata = mem[mem_addr[8:1]];
        #1;
        if (per_rd) src_ptr++;
        if (per_wr) begin sink[sink_ptr & 1023] = per_wdata; sink_ptr++; end
        if (mem_req && mem_gnt && mem_we) begin
            mem[mem_addr[8:1]] = mem_wdata; wr_log[wr_n & 255] = mem_addr; wr_n++;
        end
        if (mem_req && mem_gnt && !mem_we) rd_n++;
        if (done) done_n++;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_cnt(input logic [15:0] v);
        @(negedge clk); reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = v;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic wr_adr(input bit hi, input logic [13:0] v);
        @(negedge clk); reg_wr = 1'b1; reg_sel = 1'b1;
        reg_addr = {hi, hi ? v : {6'b0, v[7:0]}};
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic clear_log();
        src_ptr = 0; sink_ptr = 0; wr_n = 0; rd_n = 0;
    endtask

    task automatic wait_done(input string tag, input int start);
        int t = 0;
        while (done_n == start && t < 5000) begin @(negedge clk); t++; end
        check({tag, " done reached"}, (t < 5000), 1);
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [15:0] cnt_word(input bit dir, input int n);
        return {1'b1, dir, 14'(16383 - n)};
    endfunction

    // full transfer with checks: dir 0 = peripheral to memory, 1 = memory to peripheral
    task automatic run_xfer(input bit dir, input int n, input logic [21:0] base);
        int d0;
        wr_adr(1'b1, base[21:8]);
        wr_adr(1'b0, {6'b0, base[7:0]});
        clear_log();
        for (int k = 0; k < n; k++) mem[(base[7:0] + k) & 255] = 16'($urandom);
        d0 = done_n;
        wr_cnt(cnt_word(dir, n));
        check("R3 skip on enable", reg_rdata, 32'h8000 | (16383 - n + 1));
        wait_done("R2", d0);
        check("R2 single done pulse", done_n - d0, 1);
        check("R2 count cleared", reg_rdata, 16'h8000);
        if (!dir) begin
            check("R1 words stored", wr_n, n);
            for (int k = 0; k < n; k++) begin
                check("R5 store address", wr_log[k], {base + 22'(k), 1'b0});
                check("R8 byte pairing", mem[(base[7:0] + k) & 255], {src[2*k], src[2*k+1]});
            end
        end else begin
            check("R1 bytes sent", sink_ptr, 2 * n);
            check("R5 words fetched", rd_n, n);
            for (int k = 0; k < n; k++) begin
                check("R9 high byte first", sink[2*k], mem[(base[7:0] + k) & 255][15:8]);
                check("R9 low byte second", sink[2*k+1], mem[(base[7:0] + k) & 255][7:0]);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int d0, c0, s0;
        void'($urandom(32'h5EED));
        for (int i = 0; i < 1024; i++) src[i] = 8'($urandom);
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R4 reset readback", reg_rdata, 16'h8000);
        check("R2 reset idle", {mem_req, per_rd, per_wr, done}, 0);

        // R1 / R4: fields without enable, bit 14 reads zero
        wr_cnt(16'h5234);
        check("R4 readback forces bit15 set bit14 clear", reg_rdata, 16'h9234);
        clear_log();
        repeat (10) @(negedge clk);
        check("R1 no traffic without enable", wr_n + rd_n + sink_ptr + src_ptr, 0);

        // R6 / R5 / R8 / R2 / R3: directed, random pacing
        drq_mode = 0; gnt_mode = 0;
        run_xfer(1'b0, 5, 22'h000120);
        // R6: low-half write keeps the upper bits (address now 0x125)
        wr_adr(1'b0, 14'h0040);
        clear_log();
        d0 = done_n;
        wr_cnt(cnt_word(1'b0, 1));
        wait_done("R6", d0);
        check("R6 low byte replaced, upper kept", wr_log[0], {22'h000140, 1'b0});

        // R9
        run_xfer(1'b1, 4, 22'h2A3150);

        // R7: pause on data request low
        drq_mode = 1; gnt_mode = 1;
        wr_adr(1'b1, 14'h0000); wr_adr(1'b0, 14'h0060);
        clear_log(); d0 = done_n;
        wr_cnt(cnt_word(1'b0, 6));
        repeat (4) @(negedge clk);
        drq_mode = 2;
        repeat (5) @(negedge clk);
        s0 = src_ptr; c0 = reg_rdata;
        repeat (30) @(negedge clk);
        check("R7 no byte taken while request low", src_ptr, s0);
        check("R7 count holds while request low", reg_rdata, c0);
        check("R7 no strobe while request low", {per_rd, per_wr}, 0);
        drq_mode = 1;
        wait_done("R7 resume", d0);
        check("R7 all words after resume", wr_n, 6);
        for (int k = 0; k < 6; k++)
            check("R7 R8 data after resume", mem[8'h60 + k], {src[2*k], src[2*k+1]});

        // R10: slot budget
        wr_adr(1'b0, 14'h0080);
        clear_log(); d0 = done_n;
        wr_cnt(cnt_word(1'b0, 40));
        repeat (200) @(negedge clk);
        check("R10 stops at budget", wr_n, SLOT);
        check("R10 count at budget", reg_rdata, 32'h8000 | (16383 - 40 + 1 + SLOT));
        @(negedge clk); slot_tick = 1'b1; @(negedge clk); slot_tick = 1'b0;
        repeat (200) @(negedge clk);
        check("R10 second slot", wr_n, 2 * SLOT);
        @(negedge clk); slot_tick = 1'b1; @(negedge clk); slot_tick = 1'b0;
        wait_done("R10", d0);
        check("R10 total words", wr_n, 40);

        // R3: programmed 0x3FFF completes at once
        clear_log(); d0 = done_n;
        wr_cnt(16'hBFFF);
        check("R3 immediate done pulse", done, 1);
        check("R3 immediate count zero", reg_rdata, 16'h8000);
        repeat (20) @(negedge clk);
        check("R3 no data moved", wr_n + rd_n + sink_ptr + src_ptr, 0);
        check("R3 one done", done_n - d0, 1);

        // R11: request held without grant
        gnt_mode = 2;
        wr_adr(1'b0, 14'h00A0);
        clear_log(); d0 = done_n;
        wr_cnt(cnt_word(1'b1, 2));
        repeat (30) @(negedge clk);
        check("R11 request held", {mem_req, mem_we}, 2'b10);
        check("R11 nothing moved before grant", rd_n + sink_ptr, 0);
        gnt_mode = 1;
        wait_done("R11", d0);
        check("R11 bytes after grant", sink_ptr, 4);

        // random transfers
        drq_mode = 0; gnt_mode = 0;
        for (int i = 0; i < 12; i++)
            run_xfer(1'($urandom), 1 + ($urandom % SLOT), 22'($urandom) & 22'h3FFF7F);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule